// File: doc/BRIEF.md
# Serial Port Low-Power Mode Controller

This block sits beside a serial transmitter/receiver core and decides, cycle by cycle, whether that core may advance. It watches the processor's wait and stop requests, a stop-in-wait configuration bit, an interrupt wake event and a reset wake event. From them it drives a clock-enable into the core and a synchronous reset for the core. While the clock-enable is low the core holds every flop: a frame in flight freezes mid-bit, and the core's own registers are untouched.

An interrupt wake lifts the freeze on the next edge, so a frozen frame continues from the exact bit and sample where it stopped. A reset wake takes the core back to run and holds the core reset for a programmable number of cycles, which aborts any transfer. Low-power requests are ignored while that reset is active. A two-bit mode output reports run, wait-frozen or stop-frozen.

Top module: `serial_pm_ctrl`

## Requirements
- R1: While rst_ni is low, mode_o is 0 (run), core_clk_en_o is 1 and core_rst_o is 1. After release, core_rst_o stays 1 for exactly RST_CYCLES rising edges and then drops.
- R2: A wait request in run with stop_in_wait_i at 0 leaves mode_o at 0 and core_clk_en_o at 1.
- R3: A wait request in run with stop_in_wait_i at 1 sets mode_o to 1 (wait-frozen) and core_clk_en_o to 0 on the next rising edge.
- R4: A stop request sets mode_o to 2 (stop-frozen) and core_clk_en_o to 0 on the next rising edge, whatever stop_in_wait_i is. This holds from run and from wait-frozen, and a stop request wins over a wait request in the same cycle.
- R5: An interrupt wake while frozen returns mode_o to 0 and core_clk_en_o to 1 on the next rising edge, with core_rst_o left at 0.
- R6: An interrupt wake while in run has no effect on any output.
- R7: A reset wake sets mode_o to 0, core_clk_en_o to 1 and core_rst_o to 1 on the next rising edge, from any mode. It wins over a simultaneous interrupt wake. core_rst_o then stays 1 for RST_CYCLES edges after the last reset wake.
- R8: While core_rst_o is 1, wait and stop requests are ignored and mode_o stays 0.
- R9: While frozen, changing stop_in_wait_i and repeating a wait request have no effect. Only a stop request (from wait-frozen) or a wake changes mode_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low system reset |
| wait_req_i | input | 1 | Processor wait-mode request |
| stop_req_i | input | 1 | Processor stop-mode request |
| stop_in_wait_i | input | 1 | Configuration: freeze the core in wait mode |
| wake_irq_i | input | 1 | Interrupt wake event |
| wake_rst_i | input | 1 | Reset wake event, aborts the core |
| core_clk_en_o | output | 1 | Clock-enable for the serial core |
| core_rst_o | output | 1 | Synchronous reset for the serial core |
| mode_o | output | 2 | 0 run, 1 wait-frozen, 2 stop-frozen |

## Verification
The bench builds the block with RST_CYCLES set to 3. That keeps the core reset window short, so several cases fit in a few cycles: requests that land inside the window, a reset wake that re-arms the window, and a stop request on the first cycle after the window closes. A behavioural model checks all three outputs on every clock while directed phases cover wait and stop entry, wake ordering and a system reset taken while frozen.

// File: rtl/serial_pm_pkg.sv
package serial_pm_pkg;
  typedef enum logic [1:0] {
    PM_RUN  = 2'd0,
    PM_WAIT = 2'd1,
    PM_STOP = 2'd2
  } pm_mode_e;
endpackage

// File: rtl/pm_core_rst_gen.sv
module pm_core_rst_gen #(
  parameter int unsigned RST_CYCLES = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wake_rst_i,
  output logic core_rst_o
);
  localparam int unsigned CW = $clog2(RST_CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(RST_CYCLES);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= LOAD;
    else if (wake_rst_i)         cnt_q <= LOAD;
    else if (cnt_q != '0)        cnt_q <= cnt_q - 1'b1;
  end

  assign core_rst_o = (cnt_q != '0);

  a_r7_rst_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_rst_i |=> core_rst_o);
endmodule

// File: rtl/pm_mode_fsm.sv
module pm_mode_fsm
  import serial_pm_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     wait_req_i,
  input  logic     stop_req_i,
  input  logic     stop_in_wait_i,
  input  logic     wake_irq_i,
  input  logic     wake_rst_i,
  input  logic     core_busy_i,
  output pm_mode_e mode_o
);
  pm_mode_e mode_q, mode_d;

  always_comb begin
    mode_d = mode_q;
    if (wake_rst_i) begin
      mode_d = PM_RUN;
    end else begin
      unique case (mode_q)
        PM_RUN: if (!core_busy_i) begin
          if (stop_req_i)                       mode_d = PM_STOP;
          else if (wait_req_i && stop_in_wait_i) mode_d = PM_WAIT;
        end
        PM_WAIT: begin
          if (wake_irq_i)      mode_d = PM_RUN;
          else if (stop_req_i) mode_d = PM_STOP;
        end
        PM_STOP: if (wake_irq_i) mode_d = PM_RUN;
        default: mode_d = PM_RUN;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= PM_RUN;
    else         mode_q <= mode_d;
  end

  assign mode_o = mode_q;

  a_r2_no_freeze: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == PM_RUN && wait_req_i && !stop_in_wait_i && !stop_req_i && !wake_rst_i)
    |=> mode_q == PM_RUN);
  a_r3_wait_freeze: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == PM_RUN && !core_busy_i && wait_req_i && stop_in_wait_i && !stop_req_i && !wake_rst_i)
    |=> mode_q == PM_WAIT);
  a_r4_stop_freeze: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q != PM_STOP && !core_busy_i && stop_req_i && !wake_rst_i && !(mode_q == PM_WAIT && wake_irq_i))
    |=> mode_q == PM_STOP);
  a_r5_irq_resume: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q != PM_RUN && wake_irq_i) |=> mode_q == PM_RUN);
  a_r8_busy_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == PM_RUN && core_busy_i) |=> mode_q == PM_RUN);
endmodule

// File: rtl/serial_pm_ctrl.sv
module serial_pm_ctrl
  import serial_pm_pkg::*;
#(
  parameter int unsigned RST_CYCLES = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wait_req_i,
  input  logic       stop_req_i,
  input  logic       stop_in_wait_i,
  input  logic       wake_irq_i,
  input  logic       wake_rst_i,
  output logic       core_clk_en_o,
  output logic       core_rst_o,
  output logic [1:0] mode_o
);
  pm_mode_e mode;
  logic     core_rst;

  pm_core_rst_gen #(.RST_CYCLES(RST_CYCLES)) u_rst_gen (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wake_rst_i (wake_rst_i),
    .core_rst_o (core_rst)
  );

  pm_mode_fsm u_fsm (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .wait_req_i     (wait_req_i),
    .stop_req_i     (stop_req_i),
    .stop_in_wait_i (stop_in_wait_i),
    .wake_irq_i     (wake_irq_i),
    .wake_rst_i     (wake_rst_i),
    .core_busy_i    (core_rst),
    .mode_o         (mode)
  );

  // core only advances in run; frozen core keeps its state
  assign core_clk_en_o = (mode == PM_RUN);
  assign core_rst_o    = core_rst;
  assign mode_o        = mode;

  a_r5_frozen_no_rst: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode != PM_RUN) |-> !core_rst);
  a_r7_rst_to_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_rst_i |=> (core_clk_en_o && core_rst_o));
endmodule

// File: tb/tb_serial_pm_ctrl.sv
module tb_serial_pm_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int N_RST = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wait_req = 0, stop_req = 0, siw = 0, irq = 0, wrst = 0;
  logic       clk_en, core_rst;
  logic [1:0] mode;

  int checks = 0, errors = 0;
  string cur_req = "R1";
  int m_mode = 0;
  int m_cnt = N_RST;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_pm_ctrl #(.RST_CYCLES(N_RST)) dut (
    .clk_i(clk), .rst_ni(rst_n), .wait_req_i(wait_req), .stop_req_i(stop_req),
    .stop_in_wait_i(siw), .wake_irq_i(irq), .wake_rst_i(wrst),
    .core_clk_en_o(clk_en), .core_rst_o(core_rst), .mode_o(mode)
  );

  // behavioural reference
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_cnt = N_RST;
    end else begin
      bit busy;
      busy = (m_cnt != 0);
      if (wrst) begin
        m_mode = 0; m_cnt = N_RST;
      end else begin
        if (m_cnt > 0) m_cnt = m_cnt - 1;
        if (m_mode != 0 && irq)        m_mode = 0;
        else if (m_mode == 0 && !busy) begin
          if (stop_req)            m_mode = 2;
          else if (wait_req && siw) m_mode = 1;
        end else if (m_mode == 1 && stop_req) m_mode = 2;
      end
    end
  end

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      chk("mode", int'(mode), m_mode);
      chk("clk_en", int'(clk_en), (m_mode == 0) ? 1 : 0);
      chk("core_rst", int'(core_rst), (m_cnt != 0) ? 1 : 0);
    end
  end

  task automatic cyc(logic w, logic s, logic i, logic r);
    @(negedge clk); #1;
    wait_req = w; stop_req = s; irq = i; wrst = r;
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) cyc(0, 0, 0, 0);
  endtask

  initial begin
    cur_req = "R1";
    repeat (3) @(negedge clk);
    @(negedge clk); #1 rst_n = 1'b1;
    idle(6);

    cur_req = "R2"; siw = 0;
    cyc(1, 0, 0, 0); idle(3);

    cur_req = "R3"; siw = 1;
    cyc(1, 0, 0, 0); idle(4);
    cur_req = "R9"; siw = 0;
    idle(2); cyc(1, 0, 0, 0); idle(2);
    cur_req = "R5";
    cyc(0, 0, 1, 0); idle(3);

    cur_req = "R4"; siw = 0;
    cyc(0, 1, 0, 0); idle(3);
    cur_req = "R5";
    cyc(0, 0, 1, 0); idle(2);
    cur_req = "R4"; siw = 1;
    cyc(1, 0, 0, 0); idle(2); cyc(0, 1, 0, 0); idle(2);
    cur_req = "R9"; siw = 0; cyc(1, 0, 0, 0); idle(2);
    cur_req = "R5"; cyc(0, 0, 1, 0); idle(2);
    cur_req = "R4"; siw = 1;
    cyc(1, 1, 0, 0); idle(2); cyc(0, 0, 1, 0); idle(2);

    cur_req = "R6";
    cyc(0, 0, 1, 0); cyc(0, 0, 1, 0); idle(3);

    cur_req = "R7";
    cyc(0, 1, 0, 0); idle(2);
    cyc(0, 0, 1, 1); idle(5);
    cyc(0, 0, 0, 1); idle(1); cyc(0, 0, 0, 1); idle(5);

    cur_req = "R8";
    cyc(0, 0, 0, 1); cyc(0, 1, 0, 0); cyc(1, 0, 0, 0); cyc(0, 1, 0, 0);
    cyc(0, 1, 0, 0); idle(3);
    cyc(0, 0, 1, 0); idle(2);

    cur_req = "R1"; siw = 1;
    cyc(1, 0, 0, 0); idle(2);
    @(negedge clk); #1 rst_n = 1'b0;
    idle(2);
    @(negedge clk); #1 rst_n = 1'b1;
    idle(6);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule